// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block is a memory-mapped performance-monitor unit. It holds a bank of 32-bit event counters. Each counter picks its input through an 8-bit event code: the clock itself, or one of six cache event strobes that arrive as plain single-cycle inputs. Software reaches the bank over a simple 32-bit register bus. The bus has a write strobe and a combinational read port. Counters, interrupt enables and a chaining mask are programmed through that bus.

Counters form even/odd pairs. When chaining is switched on for the odd member, the odd member stops following its own event code. It then counts the wraps of its even partner, so the pair acts as one 64-bit counter. Software can flag an overflow in one of two ways. A counter flags on a plain wrap, or it flags whenever its most significant bit changes value. The second way lets a free-running counter be sampled without being reprogrammed. The flags feed a single level interrupt.

A small global controller has three states: HALT, COUNT and FLUSH. It gates all counting and provides a one-cycle clear of the counting unit. Its transitions are:
- WR_RUN moves HALT to COUNT.
- WR_STOP moves COUNT to HALT.
- WR_FLUSH moves any state to FLUSH.
- FLUSH_DONE leaves FLUSH for COUNT or HALT, according to the stored run request.

Top module: `perf_counter_bank`

## Requirements
- R1: There are eight 32-bit counters. Counter n is read and written at byte address 0x420+8n. A bus write to a counter takes priority over an increment in the same cycle, and that increment is lost. Without a write, a counter changes by at most one per clock.
- R2: The event code of counter n sits in bits 7:0 of address 0x220+8n. The codes map as follows:
  - 0x01 counts every clock.
  - 0x20+k counts cycles in which strobe bit k is high. Bit 0 is read hit, 1 is read miss, 2 is data-side read hit, 3 is data-side read miss, 4 is write hit and 5 is write miss.
  - Any other code, including 0, counts nothing.
- R3: The control register is at 0x500.
  - Writing it with bit 1 clear and bit 0 set takes WR_RUN to COUNT. Writing it with bit 1 clear and bit 0 clear takes WR_STOP to HALT. Writing bit 1 set takes WR_FLUSH to FLUSH.
  - In the FLUSH cycle, every counter value and every overflow flag is cleared. The state then follows FLUSH_DONE, back to COUNT if bit 0 was written as 1 and otherwise to HALT.
  - No counter advances outside COUNT.
  - A read returns the stored run request in bit 0 and FLUSH-in-progress in bit 1.
- R4: Counter enables are set by writing 1s to 0x508 and cleared by writing 1s to 0x50C. Bit n controls counter n, and a disabled counter holds its value. Reads of either address return the enable mask.
- R5: Interrupt enables are set by writing 1s to 0x510 and cleared by writing 1s to 0x514, and both addresses read back the mask. The irq output is high exactly while some overflow flag and its enable are both set.
- R6: At 0x718, setting odd bit n chains counter n to counter n-1. Counter n then increments in the same clock edge in which counter n-1 wraps from 0xFFFFFFFF to 0, and its own event code is ignored. Even bits cannot be set and read 0.
- R7: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag in the same edge.
- R8: Setting bit n at 0x96C switches counter n to flag on any change of bit 31, whether 0 to 1 or 1 to 0. In that mode, crossing 0x7FFFFFFF to 0x80000000 sets the flag. Without the mode, that crossing does not set the flag.
- R9: The overflow flags are read at 0x740, one bit per counter, and writing 1 clears a flag. When a new overflow and a clear hit the same flag in the same cycle, the flag stays set.
- R10: After reset, all of the following read 0: every counter, event code and per-counter control word, the enable and interrupt-enable masks, chaining, MSB mode, the flags and the filter words. irq is low.
- R11: Six filter words at 0x300, 0x304, 0x308, 0x30C, 0x310 and 0x314, and a per-counter control word at 0x120+8n, are plain 32-bit storage that reads back what was written.
- R12: Reads of unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_strobe | input | 6 | Event strobes; bit k is selected by code 0x20+k |
| irq | output | 1 | Level interrupt from enabled overflow flags |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a counter wrap setting its overflow flag and a software write-1-to-clear of that same flag. The bench provokes this by presetting a counter to 0xFFFFFFFE, starting the clock-cycle count and placing the clear write on exactly the edge of the wrap. After halting, it reads the status register and expects the flag still set.

The second pair is a bus write to a running counter and that counter's increment. The bench counts the edges around the write and expects the written value plus only the increments that come after it.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FLUSH = 2'd2
    } pcb_state_e;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h500;
    localparam logic [ADDR_W-1:0] A_EN_SET = 12'h508;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 12'h50C;
    localparam logic [ADDR_W-1:0] A_IE_SET = 12'h510;
    localparam logic [ADDR_W-1:0] A_IE_CLR = 12'h514;
    localparam logic [ADDR_W-1:0] A_GANG   = 12'h718;
    localparam logic [ADDR_W-1:0] A_OVF    = 12'h740;
    localparam logic [ADDR_W-1:0] A_MSB    = 12'h96C;

    localparam int A_CNT_BASE  = 'h420;
    localparam int A_EVT_BASE  = 'h220;
    localparam int A_CCTL_BASE = 'h120;
    localparam int A_FLT_BASE  = 'h300;

    localparam logic [7:0] EV_CYCLES      = 8'h01;
    localparam int         EV_STROBE_BASE = 'h20;

    // Mask of the bank positions that may be chained (odd ones).
    function automatic logic [31:0] odd_bits(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 1; i < n; i += 2) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
    import pcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cr_wr,
    input  logic       cr_run,
    input  logic       cr_flush,
    output pcb_state_e state,
    output logic       run,
    output logic       flush,
    output logic       run_req
);

    pcb_state_e state_q, state_d;
    logic       req_q, req_d;

    always_comb begin
        state_d = state_q;
        req_d   = req_q;
        if (cr_wr) begin
            req_d   = cr_run;
            state_d = cr_flush ? ST_FLUSH : (cr_run ? ST_COUNT : ST_HALT);
        end else begin
            unique case (state_q)
                ST_HALT:  state_d = ST_HALT;
                ST_COUNT: state_d = ST_COUNT;
                ST_FLUSH: state_d = req_q ? ST_COUNT : ST_HALT;
                default:  state_d = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_q   <= req_d;
        end
    end

    always_comb begin
        run   = 1'b0;
        flush = 1'b0;
        unique case (state_q)
            ST_HALT:  ;
            ST_COUNT: run = 1'b1;
            ST_FLUSH: flush = 1'b1;
            default:  ;
        endcase
    end

    assign state   = state_q;
    assign run_req = req_q;

endmodule

// File: rtl/pcb_slice.sv
module pcb_slice
    import pcb_pkg::*;
#(
    parameter int CW      = 32,
    parameter int NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               cnt_en,
    input  logic               flush,
    input  logic [7:0]         evsel,
    input  logic [NUM_EVT-1:0] strobe,
    input  logic               gang_on,
    input  logic               carry_in,
    input  logic               msb_mode,
    input  logic               wr_val,
    input  logic [CW-1:0]      wr_data,
    output logic [CW-1:0]      value,
    output logic               carry_out,
    output logic               ovf
);

    logic sel_hit, src, bump, all_one, low_one;

    always_comb begin
        sel_hit = (evsel == EV_CYCLES);
        for (int k = 0; k < NUM_EVT; k++) begin
            if (evsel == 8'(EV_STROBE_BASE + k)) sel_hit = sel_hit | strobe[k];
        end
    end

    assign src       = gang_on ? carry_in : sel_hit;
    assign bump      = run & cnt_en & src & ~wr_val;
    assign all_one   = &value;
    assign low_one   = &value[CW-2:0];
    assign carry_out = bump & all_one;
    assign ovf       = bump & (msb_mode ? low_one : all_one);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      value <= '0;
        else if (flush)  value <= '0;
        else if (wr_val) value <= wr_data;
        else if (bump)   value <= value + CW'(1);
    end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CW      = 32,
    parameter int NUM_EVT = 6,
    parameter int NUM_FLT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic               irq
);

    localparam int NPAIR = NUM_CNT / 2;
    localparam logic [NUM_CNT-1:0] GANG_OK = NUM_CNT'(odd_bits(NUM_CNT));

    logic [NUM_CNT-1:0] en_q, ie_q, gang_q, msb_q, ovs_q, ovf_vec;
    logic [NUM_CNT-1:0] hit_cnt, hit_evt, hit_cctl, ovs_clr;
    logic [NUM_FLT-1:0] hit_flt;
    logic [7:0]         evt_q  [NUM_CNT];
    logic [31:0]        cctl_q [NUM_CNT];
    logic [31:0]        flt_q  [NUM_FLT];
    logic [CW-1:0]      cnt_val [NUM_CNT];
    logic [NUM_CNT-1:0] wdat;

    pcb_state_e ctl_state;
    logic       ctl_run, ctl_flush, ctl_req;

    assign wdat = bus_wdata[NUM_CNT-1:0];

    pcb_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cr_wr    (bus_wr && bus_addr == A_CTRL),
        .cr_run   (bus_wdata[0]),
        .cr_flush (bus_wdata[1]),
        .state    (ctl_state),
        .run      (ctl_run),
        .flush    (ctl_flush),
        .run_req  (ctl_req)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        assign hit_cnt[i]  = bus_addr == ADDR_W'(A_CNT_BASE + 8 * i);
        assign hit_evt[i]  = bus_addr == ADDR_W'(A_EVT_BASE + 8 * i);
        assign hit_cctl[i] = bus_addr == ADDR_W'(A_CCTL_BASE + 8 * i);
    end
    for (genvar j = 0; j < NUM_FLT; j++) begin : g_fdec
        assign hit_flt[j] = bus_addr == ADDR_W'(A_FLT_BASE + 4 * j);
    end

    // Counter pairs: the odd member may count the even member's wraps.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic lo_carry, hi_carry_unused;

        pcb_slice #(.CW(CW), .NUM_EVT(NUM_EVT)) i_lo (
            .clk(clk), .rst_n(rst_n), .run(ctl_run), .cnt_en(en_q[2*p]),
            .flush(ctl_flush), .evsel(evt_q[2*p]), .strobe(evt_strobe),
            .gang_on(1'b0), .carry_in(1'b0), .msb_mode(msb_q[2*p]),
            .wr_val(bus_wr && hit_cnt[2*p]), .wr_data(bus_wdata[CW-1:0]),
            .value(cnt_val[2*p]), .carry_out(lo_carry), .ovf(ovf_vec[2*p])
        );

        pcb_slice #(.CW(CW), .NUM_EVT(NUM_EVT)) i_hi (
            .clk(clk), .rst_n(rst_n), .run(ctl_run), .cnt_en(en_q[2*p+1]),
            .flush(ctl_flush), .evsel(evt_q[2*p+1]), .strobe(evt_strobe),
            .gang_on(gang_q[2*p+1]), .carry_in(lo_carry), .msb_mode(msb_q[2*p+1]),
            .wr_val(bus_wr && hit_cnt[2*p+1]), .wr_data(bus_wdata[CW-1:0]),
            .value(cnt_val[2*p+1]), .carry_out(hi_carry_unused), .ovf(ovf_vec[2*p+1])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            ie_q   <= '0;
            gang_q <= '0;
            msb_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_EN_SET) en_q   <= en_q | wdat;
            if (bus_addr == A_EN_CLR) en_q   <= en_q & ~wdat;
            if (bus_addr == A_IE_SET) ie_q   <= ie_q | wdat;
            if (bus_addr == A_IE_CLR) ie_q   <= ie_q & ~wdat;
            if (bus_addr == A_GANG)   gang_q <= wdat & GANG_OK;
            if (bus_addr == A_MSB)    msb_q  <= wdat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CNT; i++) begin
                evt_q[i]  <= '0;
                cctl_q[i] <= '0;
            end
            for (int j = 0; j < NUM_FLT; j++) flt_q[j] <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_CNT; i++) begin
                if (hit_evt[i])  evt_q[i]  <= bus_wdata[7:0];
                if (hit_cctl[i]) cctl_q[i] <= bus_wdata;
            end
            for (int j = 0; j < NUM_FLT; j++) begin
                if (hit_flt[j]) flt_q[j] <= bus_wdata;
            end
        end
    end

    // Overflow flags: a new overflow beats a same-cycle clear.
    assign ovs_clr = (bus_wr && bus_addr == A_OVF) ? wdat : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovs_q <= '0;
        else if (ctl_flush) ovs_q <= '0;
        else                ovs_q <= (ovs_q & ~ovs_clr) | ovf_vec;
    end

    assign irq = |(ovs_q & ie_q);

    always_comb begin
        unique case (bus_addr)
            A_CTRL:             bus_rdata = {30'b0, ctl_flush, ctl_req};
            A_EN_SET, A_EN_CLR: bus_rdata = 32'(en_q);
            A_IE_SET, A_IE_CLR: bus_rdata = 32'(ie_q);
            A_GANG:             bus_rdata = 32'(gang_q);
            A_MSB:              bus_rdata = 32'(msb_q);
            A_OVF:              bus_rdata = 32'(ovs_q);
            default:            bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CNT; i++) begin
            if (hit_cnt[i])  bus_rdata = 32'(cnt_val[i]);
            if (hit_evt[i])  bus_rdata = {24'b0, evt_q[i]};
            if (hit_cctl[i]) bus_rdata = cctl_q[i];
        end
        for (int j = 0; j < NUM_FLT; j++) begin
            if (hit_flt[j]) bus_rdata = flt_q[j];
        end
    end

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
    import pcb_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CW      = 32
) (
    input logic               clk,
    input logic               rst_n,
    input pcb_state_e         state,
    input logic               bus_wr,
    input logic [NUM_CNT-1:0] ovf_vec,
    input logic [NUM_CNT-1:0] ovs_q,
    input logic [NUM_CNT-1:0] ie_q,
    input logic               irq,
    input logic [CW-1:0]      cnt_val [NUM_CNT]
);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        // R3: a halted bank does not move without a bus write
        assert_halt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_HALT && !bus_wr) |=> $stable(cnt_val[i]));

        // R1: without a write a counter steps by zero or one
        assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_wr && state != ST_FLUSH) |=>
                (cnt_val[i] == $past(cnt_val[i]) || cnt_val[i] == $past(cnt_val[i]) + CW'(1)));

        // R3: the flush cycle zeroes every counter
        assert_flush_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_FLUSH) |=> (cnt_val[i] == '0));
    end

    // R9: an overflow event always leaves its flag set, even against a clear
    assert_flag_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0) |=> ((ovs_q & $past(ovf_vec)) == $past(ovf_vec)));

    // R3: flush also drops all flags
    assert_flush_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> (ovs_q == '0));

    // R5: no interrupt while all interrupt enables are off
    assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == '0) |-> !irq);

endmodule

bind perf_counter_bank pcb_checker #(.NUM_CNT(NUM_CNT), .CW(CW)) i_pcb_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (ctl_state),
    .bus_wr  (bus_wr),
    .ovf_vec (ovf_vec),
    .ovs_q   (ovs_q),
    .ie_q    (ie_q),
    .irq     (irq),
    .cnt_val (cnt_val)
);

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_strobe = '0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    perf_counter_bank i_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe), .irq(irq)
    );

    function automatic logic [11:0] cnt_a(input int n);  return 12'('h420 + 8 * n); endfunction
    function automatic logic [11:0] evt_a(input int n);  return 12'('h220 + 8 * n); endfunction
    function automatic logic [11:0] cctl_a(input int n); return 12'('h120 + 8 * n); endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string req, input string what, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, what, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [5:0] v);
        @(negedge clk);
        evt_strobe = v;
        @(negedge clk);
        evt_strobe = '0;
    endtask

    task automatic clean();
        wr(12'h50C, 32'hFF);
        wr(12'h514, 32'hFF);
        wr(12'h718, 32'h0);
        wr(12'h96C, 32'h0);
        wr(12'h500, 32'h2);
        wr(12'h740, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        check("R10", "irq after reset", {31'b0, irq}, 32'h0);
        rd_check("R10", "enable mask", 12'h508, 32'h0);
        rd_check("R10", "irq enable mask", 12'h510, 32'h0);
        rd_check("R10", "gang", 12'h718, 32'h0);
        rd_check("R10", "msb mode", 12'h96C, 32'h0);
        rd_check("R10", "flags", 12'h740, 32'h0);
        rd_check("R10", "event code 5", evt_a(5), 32'h0);
        rd_check("R10", "counter 7", cnt_a(7), 32'h0);
        rd_check("R10", "filter 0x308", 12'h308, 32'h0);
        rd_check("R10", "control word 2", cctl_a(2), 32'h0);
    endtask

    task automatic t_cycles();
        clean();
        wr(evt_a(6), 32'h01);
        wr(12'h508, 32'h40);
        rd_check("R4", "enable mask via clear address", 12'h50C, 32'h40);
        wr(12'h500, 32'h1);
        idle(10);
        wr(12'h500, 32'h0);
        rd_check("R2", "cycle count", cnt_a(6), 32'd12);
        rd_check("R3", "control readback", 12'h500, 32'h0);
        idle(5);
        rd_check("R3", "halted counter frozen", cnt_a(6), 32'd12);
        wr(12'h50C, 32'h40);
        wr(12'h500, 32'h1);
        idle(3);
        wr(12'h500, 32'h0);
        rd_check("R4", "disabled counter holds", cnt_a(6), 32'd12);
        // R3 flush with run request: cleared, then one counted edge
        wr(12'h508, 32'h40);
        wr(12'h500, 32'h3);
        wr(12'h500, 32'h0);
        rd_check("R3", "flush then resume", cnt_a(6), 32'd1);
    endtask

    task automatic t_events();
        clean();
        wr(evt_a(1), 32'h21);
        wr(evt_a(2), 32'h25);
        wr(evt_a(3), 32'h00);
        wr(evt_a(4), 32'h26);
        wr(evt_a(5), 32'h20);
        wr(12'h508, 32'h3E);
        wr(12'h500, 32'h1);
        for (int i = 0; i < 3; i++) pulse(6'b000010);
        for (int i = 0; i < 2; i++) pulse(6'b100010);
        pulse(6'b111101);
        wr(12'h500, 32'h0);
        rd_check("R2", "read-miss code 0x21", cnt_a(1), 32'd5);
        rd_check("R2", "write-miss code 0x25", cnt_a(2), 32'd3);
        rd_check("R2", "code 0 counts nothing", cnt_a(3), 32'd0);
        rd_check("R2", "unused code 0x26", cnt_a(4), 32'd0);
        rd_check("R2", "read-hit code 0x20", cnt_a(5), 32'd1);
        rd_check("R4", "never-enabled counter", cnt_a(0), 32'd0);
        rd_check("R2", "event code readback", evt_a(1), 32'h21);
    endtask

    task automatic t_wrap_irq();
        clean();
        wr(evt_a(0), 32'h01);
        wr(cnt_a(0), 32'hFFFF_FFFD);
        wr(12'h510, 32'h1);
        wr(12'h508, 32'h1);
        wr(12'h500, 32'h1);
        idle(5);
        wr(12'h500, 32'h0);
        rd_check("R7", "wrapped value", cnt_a(0), 32'd4);
        rd_check("R7", "wrap flag", 12'h740, 32'h1);
        check("R5", "irq with flag and enable", {31'b0, irq}, 32'h1);
        wr(12'h514, 32'h1);
        check("R5", "irq masked", {31'b0, irq}, 32'h0);
        rd_check("R5", "flag kept while masked", 12'h740, 32'h1);
        wr(12'h510, 32'h1);
        wr(12'h740, 32'h1);
        rd_check("R9", "flag cleared by write-1", 12'h740, 32'h0);
        check("R5", "irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collide();
        clean();
        wr(evt_a(0), 32'h01);
        wr(cnt_a(0), 32'hFFFF_FFFE);
        wr(12'h508, 32'h1);
        wr(12'h500, 32'h1);
        wr(12'h740, 32'h1);
        wr(12'h500, 32'h0);
        rd_check("R9", "overflow beats same-cycle clear", 12'h740, 32'h1);
        rd_check("R9", "counter after collision", cnt_a(0), 32'd2);
        // R1 write beats increment
        wr(cnt_a(0), 32'h0);
        wr(12'h500, 32'h1);
        wr(cnt_a(0), 32'h100);
        wr(12'h500, 32'h0);
        rd_check("R1", "write wins over increment", cnt_a(0), 32'h102);
    endtask

    task automatic t_msb();
        clean();
        wr(evt_a(2), 32'h01);
        wr(evt_a(3), 32'h01);
        wr(cnt_a(2), 32'h7FFF_FFFE);
        wr(cnt_a(3), 32'h7FFF_FFFE);
        wr(12'h96C, 32'h4);
        wr(12'h508, 32'h0C);
        wr(12'h500, 32'h1);
        wr(12'h500, 32'h0);
        rd_check("R8", "msb crossing value", cnt_a(2), 32'h8000_0000);
        rd_check("R8", "flag only in msb mode", 12'h740, 32'h4);
        rd_check("R8", "msb mode readback", 12'h96C, 32'h4);
        wr(12'h740, 32'hFF);
        wr(cnt_a(2), 32'hFFFF_FFFF);
        wr(12'h500, 32'h1);
        wr(12'h500, 32'h0);
        rd_check("R8", "falling msb flags", 12'h740, 32'h4);
    endtask

    task automatic t_gang();
        clean();
        wr(12'h718, 32'hFF);
        rd_check("R6", "only odd gang bits", 12'h718, 32'hAA);
        wr(12'h718, 32'h2);
        wr(evt_a(0), 32'h01);
        wr(evt_a(1), 32'h01);
        wr(cnt_a(0), 32'hFFFF_FFFE);
        wr(cnt_a(1), 32'd5);
        wr(12'h508, 32'h3);
        wr(12'h500, 32'h1);
        idle(5);
        wr(12'h500, 32'h0);
        rd_check("R6", "low half", cnt_a(0), 32'd5);
        rd_check("R6", "high half counts one wrap", cnt_a(1), 32'd6);
        rd_check("R7", "low half flagged, high not", 12'h740, 32'h1);
    endtask

    task automatic t_storage();
        wr(12'h30C, 32'hDEAD_BEEF);
        rd_check("R11", "filter write readback", 12'h30C, 32'hDEAD_BEEF);
        rd_check("R11", "other filter untouched", 12'h310, 32'h0);
        wr(cctl_a(3), 32'h5A);
        rd_check("R11", "control word readback", cctl_a(3), 32'h5A);
        wr(12'h600, 32'h1234);
        rd_check("R12", "unmapped reads zero", 12'h600, 32'h0);
        rd_check("R12", "unmapped write left filter", 12'h30C, 32'hDEAD_BEEF);
        rd_check("R12", "gap address reads zero", 12'h504, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cycles();
        t_events();
        t_wrap_irq();
        t_collide();
        t_msb();
        t_gang();
        t_storage();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule